// File: doc/BRIEF.md
# Compact Instruction Expander with Mode Control

This block sits in the decode stage of a core that runs a 32-bit instruction set alongside a compact 16-bit subset. It holds the current instruction-set mode.

In full mode, each fetched 32-bit word is passed on unchanged. In compact mode, the low halfword of the fetch is expanded into the equivalent 32-bit instruction. The expansion remaps the 3-bit register codes onto full register numbers, translates the 5-bit opcode into a 6-bit opcode (plus a function code for register forms), and widens the 5-bit or 8-bit immediates to 16 bits. Whichever result applies is registered, so the next pipeline stage sees it one cycle later.

The mode never changes on ordinary instructions, which keeps it fixed for the whole of a function. Only three events can change it:
- a call that exchanges the mode toggles it;
- a return loads it from bit 0 of the return target;
- an exception forces full mode.

Top module: `cx_expander`

## Requirements
- R1: While `rst_ni` is low, `instr_o` is 0 and `valid_o`, `illegal_o` and `mode_o` are 0. Mode 0 means full and mode 1 means compact.
- R2: In full mode, a valid word on `instr_i` appears unchanged on `instr_o` one clock later, with `illegal_o` low and `valid_o` high.
- R3: In compact mode, only `instr_i[15:0]` is used. It splits as op=[15:11], rx=[10:8], ry=[7:5], imm=[4:0]. Register code c maps to register 16+c for c<2 and to register c otherwise. The full word is laid out as op6=[31:26], rs=[25:21], rt=[20:16], imm16=[15:0]. Register forms use rd=[15:11], shamt=[10:6] and funct=[5:0].
- R4: Arithmetic immediates are sign-extended from 5 bits.
  - op 0 expands to op6 0x09 with rs=rt=rx.
  - op 13 expands to op6 0x0A with rs=rx and rt=ry.
- R5: Load/store offsets are zero-extended imm scaled by the access size. In every case rs=rx and rt=ry.
  - op 1 gives op6 0x23, offset ×4.
  - op 2 gives op6 0x2B, offset ×4.
  - op 3 gives op6 0x20, offset ×1.
  - op 4 gives op6 0x28, offset ×1.
  - op 5 gives op6 0x21, offset ×2.
- R6: The stack-pointer forms use register 29 as the base and k={ry,imm} as an 8-bit field.
  - op 6 gives op6 0x23 with rt=rx and offset zext(k)×4.
  - op 7 gives op6 0x2B with rt=rx and offset zext(k)×4.
  - op 8 gives op6 0x09 with rs=rt=29 and immediate sext(k)×8.
  - op 14 gives op6 0x09 with rs=0, rt=rx and immediate zext(k).
- R7: Register forms use op6 0, with rd taken from the map of imm[4:2].
  - ops 9, 10, 11 and 12 give funct 0x21, 0x23, 0x24 and 0x25, with rs=rx and rt=ry.
  - op 15 gives funct 0x21 with rs=ry, rt=0 and rd=rx.
  - op 16 gives funct 0 with rs=0, rt=ry, rd=rx and shamt=imm.
- R8: In compact mode, ops 17 to 31 set `illegal_o` and output the no-op word 0x00000000.
- R9: An exception drives the mode to 0 on the next clock. This takes priority over a return or a call in the same cycle.
- R10: A return without an exception loads the mode from `ret_tgt_lsb_i`. This takes priority over a call in the same cycle.
- R11: A call with exchange, with no return and no exception in the same cycle, toggles the mode.
- R12: Without any of the three events the mode holds. An instruction is expanded under the mode shown in the cycle it is presented, even if an event in that cycle changes the mode.
- R13: When `valid_i` is low, `valid_o` and `illegal_o` go low one clock later and `instr_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Fetched instruction is valid |
| instr_i | input | 32 | Fetched word; only bits 15:0 are used in compact mode |
| call_x_i | input | 1 | Call that exchanges the mode |
| ret_i | input | 1 | Return through the link register |
| ret_tgt_lsb_i | input | 1 | Bit 0 of the return target address |
| exc_i | input | 1 | Exception taken |
| instr_o | output | 32 | Expanded or passed-through instruction |
| valid_o | output | 1 | Output instruction is valid |
| illegal_o | output | 1 | Undefined compact opcode |
| mode_o | output | 1 | Current mode: 0 full, 1 compact |

## Verification
The bench walks every defined compact opcode, using operands that hit the corner cases:
- the register codes 0 and 1 that leave the identity map, which a naive design would send to registers 0 and 1;
- all-ones immediates, where a missing sign extension or a wrong scale shows up at once;
- negative stack adjustments, which catch a zero-extension mistake.

Two undefined opcodes must produce a zero word with the flag set, rather than some stray expansion.

Simultaneous events check the priority order, since a design that lets a call beat a return toggles the mode away from the target's bit. An instruction presented in the same cycle as a call checks that it is decoded under the old mode, not the new one.

A cycle with `valid_i` low checks that `instr_o` holds its value and that the flag drops.

// File: rtl/cx_pkg.sv
package cx_pkg;
  localparam int unsigned ILEN = 32;
  localparam int unsigned CLEN = 16;
  localparam int unsigned C_REG_W = 3;
  localparam int unsigned F_REG_W = 5;

  typedef enum logic [4:0] {
    C_ADDI   = 5'd0,
    C_LDW    = 5'd1,
    C_STW    = 5'd2,
    C_LDB    = 5'd3,
    C_STB    = 5'd4,
    C_LDH    = 5'd5,
    C_LDW_SP = 5'd6,
    C_STW_SP = 5'd7,
    C_ADJ_SP = 5'd8,
    C_ADD    = 5'd9,
    C_SUB    = 5'd10,
    C_AND    = 5'd11,
    C_OR     = 5'd12,
    C_SLTI   = 5'd13,
    C_LI     = 5'd14,
    C_MOV    = 5'd15,
    C_SLL    = 5'd16
  } c_op_e;

  typedef struct packed {
    logic [4:0]         op;
    logic [C_REG_W-1:0] rx;
    logic [C_REG_W-1:0] ry;
    logic [4:0]         imm;
  } c_instr_t;

  localparam logic [5:0] F_RTYPE = 6'h00;
  localparam logic [5:0] F_ADDIU = 6'h09;
  localparam logic [5:0] F_SLTI  = 6'h0A;
  localparam logic [5:0] F_LB    = 6'h20;
  localparam logic [5:0] F_LH    = 6'h21;
  localparam logic [5:0] F_LW    = 6'h23;
  localparam logic [5:0] F_SB    = 6'h28;
  localparam logic [5:0] F_SW    = 6'h2B;

  localparam logic [5:0] FN_SLL  = 6'h00;
  localparam logic [5:0] FN_ADDU = 6'h21;
  localparam logic [5:0] FN_SUBU = 6'h23;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;

  localparam logic [ILEN-1:0] NOP_WORD = '0;
endpackage

// File: rtl/cx_regmap.sv
module cx_regmap #(
  parameter int unsigned C_REG_W = 3,
  parameter int unsigned F_REG_W = 5,
  parameter int unsigned HI_BASE = 16,
  parameter int unsigned HI_CNT  = 2
) (
  input  logic [C_REG_W-1:0] code_i,
  output logic [F_REG_W-1:0] reg_o
);
  localparam logic [F_REG_W-1:0] BASE  = F_REG_W'(HI_BASE);
  localparam logic [C_REG_W-1:0] LIMIT = C_REG_W'(HI_CNT);

  always_comb begin
    if (code_i < LIMIT) reg_o = BASE + F_REG_W'(code_i);
    else                reg_o = F_REG_W'(code_i);
  end
endmodule

// File: rtl/cx_expand.sv
module cx_expand
  import cx_pkg::*;
#(
  parameter int unsigned SP_REG = 29
) (
  input  c_instr_t            c_i,
  input  logic [F_REG_W-1:0]  rx_f_i,
  input  logic [F_REG_W-1:0]  ry_f_i,
  input  logic [F_REG_W-1:0]  rd_f_i,
  output logic [ILEN-1:0]     word_o,
  output logic                illegal_o
);
  localparam logic [F_REG_W-1:0] SP   = F_REG_W'(SP_REG);
  localparam logic [F_REG_W-1:0] ZREG = '0;

  logic [15:0] sext5, zext5, zext5_x2, zext5_x4;
  logic [15:0] k_x4, k_sx8, k_z;
  logic [7:0]  k8;

  always_comb begin
    k8       = {c_i.ry, c_i.imm};
    sext5    = {{11{c_i.imm[4]}}, c_i.imm};
    zext5    = {11'b0, c_i.imm};
    zext5_x2 = {10'b0, c_i.imm, 1'b0};
    zext5_x4 = {9'b0, c_i.imm, 2'b0};
    k_x4     = {6'b0, k8, 2'b0};
    k_sx8    = {{5{k8[7]}}, k8, 3'b0};
    k_z      = {8'b0, k8};
  end

  always_comb begin
    illegal_o = 1'b0;
    word_o    = NOP_WORD;
    case (c_i.op)
      C_ADDI:   word_o = {F_ADDIU, rx_f_i, rx_f_i, sext5};
      C_LDW:    word_o = {F_LW, rx_f_i, ry_f_i, zext5_x4};
      C_STW:    word_o = {F_SW, rx_f_i, ry_f_i, zext5_x4};
      C_LDB:    word_o = {F_LB, rx_f_i, ry_f_i, zext5};
      C_STB:    word_o = {F_SB, rx_f_i, ry_f_i, zext5};
      C_LDH:    word_o = {F_LH, rx_f_i, ry_f_i, zext5_x2};
      C_LDW_SP: word_o = {F_LW, SP, rx_f_i, k_x4};
      C_STW_SP: word_o = {F_SW, SP, rx_f_i, k_x4};
      C_ADJ_SP: word_o = {F_ADDIU, SP, SP, k_sx8};
      C_ADD:    word_o = {F_RTYPE, rx_f_i, ry_f_i, rd_f_i, 5'd0, FN_ADDU};
      C_SUB:    word_o = {F_RTYPE, rx_f_i, ry_f_i, rd_f_i, 5'd0, FN_SUBU};
      C_AND:    word_o = {F_RTYPE, rx_f_i, ry_f_i, rd_f_i, 5'd0, FN_AND};
      C_OR:     word_o = {F_RTYPE, rx_f_i, ry_f_i, rd_f_i, 5'd0, FN_OR};
      C_SLTI:   word_o = {F_SLTI, rx_f_i, ry_f_i, sext5};
      C_LI:     word_o = {F_ADDIU, ZREG, rx_f_i, k_z};
      C_MOV:    word_o = {F_RTYPE, ry_f_i, ZREG, rx_f_i, 5'd0, FN_ADDU};
      C_SLL:    word_o = {F_RTYPE, ZREG, ry_f_i, rx_f_i, c_i.imm, FN_SLL};
      default:  illegal_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/cx_mode_ctrl.sv
module cx_mode_ctrl #(
  parameter logic RESET_MODE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic call_x_i,
  input  logic ret_i,
  input  logic ret_tgt_lsb_i,
  input  logic exc_i,
  output logic mode_o
);
  logic mode_q, mode_d;

  // exception > return > call
  always_comb begin
    mode_d = mode_q;
    if (exc_i)         mode_d = 1'b0;
    else if (ret_i)    mode_d = ret_tgt_lsb_i;
    else if (call_x_i) mode_d = ~mode_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= RESET_MODE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/cx_expander.sv
module cx_expander
  import cx_pkg::*;
#(
  parameter int unsigned SP_REG     = 29,
  parameter int unsigned HI_BASE    = 16,
  parameter int unsigned HI_CNT     = 2,
  parameter logic        RESET_MODE = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  input  logic            call_x_i,
  input  logic            ret_i,
  input  logic            ret_tgt_lsb_i,
  input  logic            exc_i,
  output logic [31:0]     instr_o,
  output logic            valid_o,
  output logic            illegal_o,
  output logic            mode_o
);
  localparam int unsigned N_FIELDS = 3;

  c_instr_t            c_w;
  logic [C_REG_W-1:0]  code_w [N_FIELDS];
  logic [F_REG_W-1:0]  freg_w [N_FIELDS];
  logic [ILEN-1:0]     exp_word;
  logic                exp_ill;
  logic                mode_w;
  logic [ILEN-1:0]     instr_q;
  logic                valid_q, illegal_q;

  assign c_w       = c_instr_t'(instr_i[CLEN-1:0]);
  assign code_w[0] = c_w.rx;
  assign code_w[1] = c_w.ry;
  assign code_w[2] = c_w.imm[4:2];

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_map
    cx_regmap #(
      .C_REG_W(C_REG_W),
      .F_REG_W(F_REG_W),
      .HI_BASE(HI_BASE),
      .HI_CNT (HI_CNT)
    ) u_map (
      .code_i(code_w[g]),
      .reg_o (freg_w[g])
    );
  end

  cx_expand #(.SP_REG(SP_REG)) u_expand (
    .c_i      (c_w),
    .rx_f_i   (freg_w[0]),
    .ry_f_i   (freg_w[1]),
    .rd_f_i   (freg_w[2]),
    .word_o   (exp_word),
    .illegal_o(exp_ill)
  );

  cx_mode_ctrl #(.RESET_MODE(RESET_MODE)) u_mode (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .call_x_i     (call_x_i),
    .ret_i        (ret_i),
    .ret_tgt_lsb_i(ret_tgt_lsb_i),
    .exc_i        (exc_i),
    .mode_o       (mode_w)
  );

  // decode uses the mode in force this cycle, not the one an event sets
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      instr_q   <= '0;
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        instr_q   <= mode_w ? exp_word : instr_i;
        illegal_q <= mode_w & exp_ill;
      end else begin
        illegal_q <= 1'b0;
      end
    end
  end

  assign instr_o   = instr_q;
  assign valid_o   = valid_q;
  assign illegal_o = illegal_q;
  assign mode_o    = mode_w;
endmodule

// File: rtl/cx_expander_chk.sv
module cx_expander_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        valid_i,
  input logic [31:0] instr_i,
  input logic        call_x_i,
  input logic        ret_i,
  input logic        ret_tgt_lsb_i,
  input logic        exc_i,
  input logic [31:0] instr_o,
  input logic        valid_o,
  input logic        illegal_o,
  input logic        mode_o
);
  a_r2_full_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !mode_o |=> instr_o == $past(instr_i) && !illegal_o);

  a_r2_valid_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> valid_o == $past(valid_i));

  a_r8_illegal_nop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> instr_o == 32'h0);

  a_r8_illegal_compact_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> $past(mode_o));

  a_r9_exc_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_i |=> !mode_o);

  a_r10_ret_lsb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_i && !exc_i |=> mode_o == $past(ret_tgt_lsb_i));

  a_r11_call_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    call_x_i && !ret_i && !exc_i |=> mode_o != $past(mode_o));

  a_r12_mode_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !call_x_i && !ret_i && !exc_i |=> $stable(mode_o));

  a_r13_hold_out: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(instr_o) && !illegal_o && !valid_o);
endmodule

bind cx_expander cx_expander_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .valid_i      (valid_i),
  .instr_i      (instr_i),
  .call_x_i     (call_x_i),
  .ret_i        (ret_i),
  .ret_tgt_lsb_i(ret_tgt_lsb_i),
  .exc_i        (exc_i),
  .instr_o      (instr_o),
  .valid_o      (valid_o),
  .illegal_o    (illegal_o),
  .mode_o       (mode_o)
);

// File: tb/cx_expander_tb_top.sv
module cx_expander_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 21;

  // {compact halfword, expected word, expected illegal}
  localparam logic [48:0] VEC [NV] = '{
    {{5'd0,  3'd1, 3'd0, 5'h1F}, {6'h09, 5'd17, 5'd17, 16'hFFFF}, 1'b0},
    {{5'd0,  3'd3, 3'd0, 5'h0F}, {6'h09, 5'd3,  5'd3,  16'h000F}, 1'b0},
    {{5'd1,  3'd2, 3'd0, 5'h1F}, {6'h23, 5'd2,  5'd16, 16'h007C}, 1'b0},
    {{5'd2,  3'd7, 3'd1, 5'h03}, {6'h2B, 5'd7,  5'd17, 16'h000C}, 1'b0},
    {{5'd3,  3'd4, 3'd5, 5'h1F}, {6'h20, 5'd4,  5'd5,  16'h001F}, 1'b0},
    {{5'd4,  3'd0, 3'd6, 5'h10}, {6'h28, 5'd16, 5'd6,  16'h0010}, 1'b0},
    {{5'd5,  3'd5, 3'd3, 5'h1F}, {6'h21, 5'd5,  5'd3,  16'h003E}, 1'b0},
    {{5'd6,  3'd0, 3'd7, 5'h1F}, {6'h23, 5'd29, 5'd16, 16'h03FC}, 1'b0},
    {{5'd7,  3'd6, 3'd0, 5'h01}, {6'h2B, 5'd29, 5'd6,  16'h0004}, 1'b0},
    {{5'd8,  3'd0, 3'd7, 5'h18}, {6'h09, 5'd29, 5'd29, 16'hFFC0}, 1'b0},
    {{5'd8,  3'd0, 3'd1, 5'h00}, {6'h09, 5'd29, 5'd29, 16'h0100}, 1'b0},
    {{5'd17, 3'd2, 3'd3, 5'h04}, 32'h0000_0000, 1'b1},
    {{5'd9,  3'd2, 3'd3, 5'h10}, {6'h00, 5'd2,  5'd3,  5'd4,  5'd0,  6'h21}, 1'b0},
    {{5'd10, 3'd0, 3'd1, 5'h07}, {6'h00, 5'd16, 5'd17, 5'd17, 5'd0,  6'h23}, 1'b0},
    {{5'd11, 3'd7, 3'd6, 5'h14}, {6'h00, 5'd7,  5'd6,  5'd5,  5'd0,  6'h24}, 1'b0},
    {{5'd12, 3'd4, 3'd4, 5'h00}, {6'h00, 5'd4,  5'd4,  5'd16, 5'd0,  6'h25}, 1'b0},
    {{5'd31, 3'd7, 3'd7, 5'h1F}, 32'h0000_0000, 1'b1},
    {{5'd13, 3'd3, 3'd0, 5'h10}, {6'h0A, 5'd3,  5'd16, 16'hFFF0}, 1'b0},
    {{5'd14, 3'd1, 3'd7, 5'h1F}, {6'h09, 5'd0,  5'd17, 16'h00FF}, 1'b0},
    {{5'd15, 3'd5, 3'd0, 5'h00}, {6'h00, 5'd16, 5'd0,  5'd5,  5'd0,  6'h21}, 1'b0},
    {{5'd16, 3'd6, 3'd2, 5'h1F}, {6'h00, 5'd0,  5'd2,  5'd6,  5'd31, 6'h00}, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic        call_x_i = 1'b0;
  logic        ret_i = 1'b0;
  logic        ret_tgt_lsb_i = 1'b0;
  logic        exc_i = 1'b0;
  logic [31:0] instr_o;
  logic        valid_o, illegal_o, mode_o;

  int checks = 0;
  int failures = 0;
  logic [31:0] last_word;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cx_expander dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .call_x_i(call_x_i), .ret_i(ret_i), .ret_tgt_lsb_i(ret_tgt_lsb_i),
    .exc_i(exc_i), .instr_o(instr_o), .valid_o(valid_o),
    .illegal_o(illegal_o), .mode_o(mode_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
  endtask

  task automatic events(input logic c, input logic r, input logic l, input logic e);
    call_x_i = c; ret_i = r; ret_tgt_lsb_i = l; exc_i = e;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    cyc(); cyc();
    check("R1 instr", instr_o, 32'h0);
    check("R1 valid", {31'b0, valid_o}, 32'h0);
    check("R1 illegal", {31'b0, illegal_o}, 32'h0);
    check("R1 mode", {31'b0, mode_o}, 32'h0);
    rst_ni = 1'b1;

    // R2 full-mode passthrough
    valid_i = 1'b1; instr_i = 32'hDEAD_BEEF;
    cyc();
    check("R2 word", instr_o, 32'hDEAD_BEEF);
    check("R2 valid", {31'b0, valid_o}, 32'h1);
    instr_i = 32'h0000_F800; // low half would be undefined compact op
    cyc();
    check("R2 word no expand", instr_o, 32'h0000_F800);
    check("R2 no illegal", {31'b0, illegal_o}, 32'h0);

    // R12/R11: call with an instruction in the same cycle uses old mode
    instr_i = 32'h1234_5678; events(1, 0, 0, 0);
    cyc();
    events(0, 0, 0, 0);
    check("R12 old mode decode", instr_o, 32'h1234_5678);
    check("R11 toggle to compact", {31'b0, mode_o}, 32'h1);

    // table walk, compact mode (R3..R8)
    for (int i = 0; i < NV; i++) begin
      instr_i = {16'hA5A5, VEC[i][48:33]};
      cyc();
      check($sformatf("R3-expand vec%0d R4 R5 R6 R7", i), instr_o, VEC[i][32:1]);
      check($sformatf("R8 illegal vec%0d", i), {31'b0, illegal_o}, {31'b0, VEC[i][0]});
      check("R12 mode held", {31'b0, mode_o}, 32'h1);
    end
    last_word = VEC[NV-1][32:1];

    // R13 invalid input holds output
    valid_i = 1'b0; instr_i = {16'h0, 5'd31, 11'h0};
    cyc();
    check("R13 valid low", {31'b0, valid_o}, 32'h0);
    check("R13 illegal low", {31'b0, illegal_o}, 32'h0);
    check("R13 hold", instr_o, last_word);
    valid_i = 1'b1;
    cyc();
    check("R13 then R8 illegal", {31'b0, illegal_o}, 32'h1);

    // R10 return
    valid_i = 1'b0;
    events(0, 1, 0, 0); cyc();
    check("R10 ret lsb0", {31'b0, mode_o}, 32'h0);
    events(0, 1, 1, 0); cyc();
    check("R10 ret lsb1", {31'b0, mode_o}, 32'h1);
    events(1, 1, 1, 0); cyc();
    check("R10 ret beats call", {31'b0, mode_o}, 32'h1);

    // R9 exception
    events(1, 1, 1, 1); cyc();
    check("R9 exc beats all", {31'b0, mode_o}, 32'h0);
    events(0, 0, 0, 1); cyc();
    check("R9 exc in full", {31'b0, mode_o}, 32'h0);

    // R11 toggle both ways
    events(1, 0, 0, 0); cyc();
    check("R11 to compact", {31'b0, mode_o}, 32'h1);
    cyc();
    check("R11 back to full", {31'b0, mode_o}, 32'h0);

    // R12 hold without events
    events(0, 0, 1, 0);
    valid_i = 1'b1; instr_i = 32'h0000_0000;
    repeat (3) cyc();
    check("R12 hold full", {31'b0, mode_o}, 32'h0);
    check("R2 zero word", instr_o, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule